// File: doc/BRIEF.md
# PCI Master Bus Request Sequencer

This block sits on the request side of a PCI bus master inside a DMA engine. When the DMA engine asks for a transfer, the sequencer requests the bus from the central arbiter. It waits for a grant together with an idle bus, then opens the address phase. During the transaction it drives the frame strobe, the 64-bit request strobe, the command/byte-enable drive enable and the parity drive enables. The data path, the address decode and the parity value itself belong to neighbouring logic. This block only decides when each strobe is active.

When a target ends a transaction with a stop, the sequencer withdraws its bus request. It keeps the request off for a minimum number of clocks, and at least one of those clocks must show an idle bus. This gives other masters a window on the bus while the stopping target gets ready. The withdrawal is skipped when the stop arrives after the frame strobe was already released for the last data phase and the grant is still held. In that case the master keeps requesting and may start its next transaction at once.

Top module: `pci_mreq_seq`

## Requirements
- R1: A synchronous active-low reset drives `req_n`, `frame_n` and `req64_n` high and `cbe_oe`, `par_oe` and `par64_oe` low from the first clock edge at which reset is sampled low.
- R2: While the sequencer is idle, a high `dma_start` sampled at a clock edge drives `req_n` low after that edge.
- R3: While requesting, the address phase opens (`frame_n` low, `cbe_oe` high) on the edge after the first clock that samples `gnt_n` low and `bus_idle` high together. A grant on a busy bus has no effect, and so does a grant that is withdrawn before the address phase: `req_n` stays low and `frame_n` stays high.
- R4: `par_oe` equals `cbe_oe` delayed by one clock. `par64_oe` follows it in the same way, but only in a 64-bit transaction.
- R5: `wide_mode` is sampled when the grant is taken. In a 64-bit transaction `req64_n` is low exactly while `frame_n` is low. In a 32-bit transaction `req64_n` stays high.
- R6: A high `last_phase` during the address or data phase drives `frame_n` and `req64_n` high after the next edge, while `cbe_oe` stays high until the transaction ends.
- R7: A high `xfer_done` in the data phase ends the transaction: `frame_n` goes high and `cbe_oe` goes low. `req_n` stays low if `dma_start` is high, and otherwise goes high. No back-off follows.
- R8: A high `tgt_stop` in the data phase, with `frame_n` still low or with `gnt_n` high, drives `req_n` high. `req_n` then stays high for at least 2 clocks and until at least one clock has sampled `bus_idle` high.
- R9: After a stop back-off, `req_n` goes low on the edge at which both the clock count (2) and the idle count (1) are reached, if `dma_start` is high.
- R10: A high `tgt_stop` that arrives after `frame_n` is already high, with `gnt_n` low and `dma_start` high, leaves `req_n` low with no gap, and a new address phase may open on the next granted idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_start | input | 1 | DMA engine wants a transfer |
| wide_mode | input | 1 | 1 = 64-bit transaction |
| gnt_n | input | 1 | Arbiter grant, active low |
| bus_idle | input | 1 | Frame and initiator-ready both high on the bus |
| tgt_stop | input | 1 | Target terminated the transaction |
| last_phase | input | 1 | Data engine is entering its last data phase |
| xfer_done | input | 1 | Transaction completed normally |
| req_n | output | 1 | Bus request, active low |
| frame_n | output | 1 | Frame strobe, active low |
| req64_n | output | 1 | 64-bit request strobe, active low |
| cbe_oe | output | 1 | Drive command/byte enables |
| par_oe | output | 1 | Drive parity |
| par64_oe | output | 1 | Drive upper parity |

## Verification
The bench targets the stop back-off in two forms. In one, the bus stays busy past the second clock; a design that counted only clocks would re-request before any idle clock. In the other, the bus is idle from the start; a design that counted only idle clocks would release after one clock. It also checks the fast restart after a stop during the last phase, where a design that always backed off would drop the request needlessly. It changes `wide_mode` after the grant, so a design that did not latch the mode would lose the upper parity enable. Finally, it withdraws the grant before the address phase and grants on a busy bus, where a wrong design would open a frame too early.

// File: rtl/pci_mreq_seq.sv
module pci_mreq_seq #(
  parameter int OFF_CLKS  = 2,
  parameter int IDLE_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_start,
  input  logic wide_mode,
  input  logic gnt_n,
  input  logic bus_idle,
  input  logic tgt_stop,
  input  logic last_phase,
  input  logic xfer_done,
  output logic req_n,
  output logic frame_n,
  output logic req64_n,
  output logic cbe_oe,
  output logic par_oe,
  output logic par64_oe
);

  localparam int CW = (OFF_CLKS  < 2) ? 1 : $clog2(OFF_CLKS + 1);
  localparam int IW = (IDLE_CLKS < 2) ? 1 : $clog2(IDLE_CLKS + 1);
  localparam logic [CW-1:0] TOT_MAX  = CW'(OFF_CLKS);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CLKS);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_BACK} st_t;

  st_t           st;
  logic [CW-1:0] tot;
  logic [IW-1:0] idl;
  logic          wide_q;

  logic [CW-1:0] tot_nx;
  logic [IW-1:0] idl_nx;
  logic          back_ok;
  logic          grab;
  logic          fast_ok;

  assign tot_nx  = (tot == TOT_MAX) ? tot : tot + CW'(1);
  assign idl_nx  = (bus_idle && idl != IDLE_MAX) ? idl + IW'(1) : idl;
  assign back_ok = (tot_nx == TOT_MAX) && (idl_nx == IDLE_MAX);
  assign grab    = !gnt_n && bus_idle;
  assign fast_ok = frame_n && !gnt_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tot      <= '0;
      idl      <= '0;
      wide_q   <= 1'b0;
      req_n    <= 1'b1;
      frame_n  <= 1'b1;
      req64_n  <= 1'b1;
      cbe_oe   <= 1'b0;
      par_oe   <= 1'b0;
      par64_oe <= 1'b0;
    end else begin
      par_oe   <= cbe_oe;
      par64_oe <= cbe_oe && wide_q;
      case (st)
        S_IDLE: begin
          if (dma_start) begin
            st    <= S_REQ;
            req_n <= 1'b0;
          end
        end
        S_REQ: begin
          if (grab) begin
            st      <= S_ADDR;
            frame_n <= 1'b0;
            req64_n <= !wide_mode;
            wide_q  <= wide_mode;
            cbe_oe  <= 1'b1;
          end
        end
        S_ADDR: begin
          st <= S_DATA;
          if (last_phase) begin
            frame_n <= 1'b1;
            req64_n <= 1'b1;
          end
        end
        S_DATA: begin
          if (tgt_stop || xfer_done) begin
            frame_n <= 1'b1;
            req64_n <= 1'b1;
            cbe_oe  <= 1'b0;
            if (tgt_stop && !fast_ok) begin
              st    <= S_BACK;
              req_n <= 1'b1;
              tot   <= '0;
              idl   <= '0;
            end else if (dma_start) begin
              st <= S_REQ;
            end else begin
              st    <= S_IDLE;
              req_n <= 1'b1;
            end
          end else if (last_phase) begin
            frame_n <= 1'b1;
            req64_n <= 1'b1;
          end
        end
        S_BACK: begin
          tot <= tot_nx;
          idl <= idl_nx;
          if (back_ok) begin
            st    <= dma_start ? S_REQ : S_IDLE;
            req_n <= !dma_start;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_mreq_seq_chk.sv
module pci_mreq_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_start,
  input logic wide_mode,
  input logic gnt_n,
  input logic bus_idle,
  input logic tgt_stop,
  input logic last_phase,
  input logic xfer_done,
  input logic req_n,
  input logic frame_n,
  input logic req64_n,
  input logic cbe_oe,
  input logic par_oe,
  input logic par64_oe
);

  logic in_rst, req_q, stop_q, bo, seen;

  always_ff @(posedge clk) begin
    in_rst <= !rst_n;
    if (!rst_n) begin
      req_q  <= 1'b1;
      stop_q <= 1'b0;
      bo     <= 1'b0;
      seen   <= 1'b0;
    end else begin
      req_q  <= req_n;
      stop_q <= tgt_stop;
      if (req_n && !req_q && stop_q) begin
        bo   <= 1'b1;
        seen <= bus_idle;
      end else if (bo && !req_n) begin
        bo <= 1'b0;
      end else if (bo && bus_idle) begin
        seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_rst) begin
      p_reset_idle_r1: assert (req_n && frame_n && req64_n && !cbe_oe && !par_oe && !par64_oe)
        else $error("reset state");
    end
  end

  p_frame_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(!gnt_n && bus_idle));

  p_par_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cbe_oe |=> par_oe);

  p_par_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cbe_oe |=> !par_oe);

  p_par64_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    par64_oe |-> par_oe);

  p_req64_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req64_n |-> !frame_n);

  p_gap_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_n) && $past(tgt_stop)) |=> req_n);

  p_idle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bo && $fell(req_n)) |-> seen);

endmodule

bind pci_mreq_seq pci_mreq_seq_chk u_chk (.*);

// File: tb/tb_pci_mreq_seq.sv
module tb_pci_mreq_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic dma_start, wide_mode, gnt_n, bus_idle, tgt_stop, last_phase, xfer_done;
  logic req_n, frame_n, req64_n, cbe_oe, par_oe, par64_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pci_mreq_seq dut (
    .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .wide_mode(wide_mode),
    .gnt_n(gnt_n), .bus_idle(bus_idle), .tgt_stop(tgt_stop),
    .last_phase(last_phase), .xfer_done(xfer_done), .req_n(req_n),
    .frame_n(frame_n), .req64_n(req64_n), .cbe_oe(cbe_oe),
    .par_oe(par_oe), .par64_oe(par64_oe)
  );

  // {req tag, {dma,gnt_n,idle,stop,last,done,wide}, {req_n,frame_n,req64_n,cbe,par,par64}}
  localparam int NV = 27;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2,  7'b1110000, 6'b011000},  // R2 request
    {4'd3,  7'b1000001, 6'b011000},  // R3 grant on busy bus
    {4'd3,  7'b1110001, 6'b011000},  // R3 grant withdrawn
    {4'd3,  7'b1010001, 6'b000100},  // R3 R5 address phase, 64-bit
    {4'd4,  7'b1000001, 6'b000111},  // R4 parity lag
    {4'd8,  7'b1001001, 6'b111011},  // R8 stop with frame low
    {4'd8,  7'b1000000, 6'b111000},  // R8 busy
    {4'd8,  7'b1000000, 6'b111000},  // R8 two clocks, no idle yet
    {4'd9,  7'b1010000, 6'b011000},  // R9 release on idle
    {4'd5,  7'b1010000, 6'b001100},  // R5 32-bit address
    {4'd6,  7'b1000100, 6'b011110},  // R6 last in address phase
    {4'd10, 7'b1001000, 6'b011010},  // R10 fast restart
    {4'd10, 7'b1010001, 6'b000100},  // R10 new address at once
    {4'd4,  7'b1000000, 6'b000111},  // R4 mode latched at grant
    {4'd7,  7'b0000010, 6'b111011},  // R7 done, no more work
    {4'd7,  7'b0010000, 6'b111000},  // R7 idle ignores grant
    {4'd2,  7'b1100000, 6'b011000},  // R2
    {4'd3,  7'b1010000, 6'b001100},  // R3
    {4'd6,  7'b1000100, 6'b011110},  // R6
    {4'd8,  7'b1101000, 6'b111010},  // R8 last phase but grant lost
    {4'd8,  7'b1110000, 6'b111000},  // R8 idle at once, still two clocks
    {4'd9,  7'b1110000, 6'b011000},  // R9
    {4'd3,  7'b1010000, 6'b001100},  // R3
    {4'd4,  7'b1000000, 6'b001110},  // R4
    {4'd6,  7'b1000100, 6'b011110},  // R6 last in data phase
    {4'd7,  7'b1000010, 6'b011010},  // R7 done, more work
    {4'd3,  7'b1110000, 6'b011000}   // R3 waiting again
  };

  task automatic drive(input logic [6:0] v);
    {dma_start, gnt_n, bus_idle, tgt_stop, last_phase, xfer_done, wide_mode} = v;
  endtask

  task automatic check(input int tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {req_n, frame_n, req64_n, cbe_oe, par_oe, par64_oe};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(7'b0);
    repeat (3) @(negedge clk);
    check(1, 6'b111000);   // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12:6]);
      @(negedge clk);
      check(int'(VEC[i][16:13]), VEC[i][5:0]);
    end
    // R1: reset in the middle of a 64-bit transaction
    drive(7'b1010001);
    @(negedge clk);
    check(3, 6'b000100);
    drive(7'b1000001);
    @(negedge clk);
    check(4, 6'b000111);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 6'b111000);   // R1
    rst_n = 1'b1;
    drive(7'b0);
    @(negedge clk);
    check(1, 6'b111000);   // R1 stays idle without dma_start
    finish_run();
  end

endmodule